// File: doc/BRIEF.md
# AXI Manager Channel Activity Monitor

This block sits passively beside the five channels of an AXI4 manager port, for example the port of a DMA engine. It only observes the valid, ready, burst length, burst size and write-strobe signals, and it drives nothing back onto the bus. From these observations it produces a set of single-cycle event flags for every cycle, together with byte counts that an external performance counter can add up.

For each channel it separates three conditions. A stall means the manager is being held up by the subordinate. A buffer stall means the subordinate is ready but the manager has nothing to offer or accept. A handshake means a transfer took place. On an address handshake the monitor reports the total size of the burst in bytes. On a data handshake it reports the bytes carried by that beat. A busy flag copies the engine's busy input. Every output is registered, so each one describes the channel state sampled one clock earlier.

Top module: `axi_activity_monitor`

## Requirements
- R1: `aw_stall_o` is 1 exactly one cycle after a cycle with `aw_valid`=1 and `aw_ready`=0. `ar_stall_o` follows the same rule with `ar_valid`/`ar_ready`.
- R2: `w_stall_o` is 1 one cycle after `w_valid`=1 with `w_ready`=0. `w_idle_o` is 1 one cycle after `w_ready`=1 with `w_valid`=0.
- R3: `r_stall_o` is 1 one cycle after `r_ready`=1 with `r_valid`=0. `r_idle_o` is 1 one cycle after `r_valid`=1 with `r_ready`=0.
- R4: Each of `aw_done_o`, `ar_done_o`, `w_done_o`, `r_done_o` and `b_done_o` is 1 one cycle after a cycle in which both valid and ready of its channel are 1.
- R5: `aw_bytes_o` (and `ar_bytes_o`) is (len+1)·2^size one cycle after a handshake on that address channel, and 0 otherwise. len is the unsigned burst length field and size is the unsigned size exponent field.
- R6: `w_bytes_o` equals the number of 1 bits in `w_strb` one cycle after a W handshake, and 0 otherwise.
- R7: `r_bytes_o` equals DATA_W/8 one cycle after an R handshake, and 0 otherwise.
- R8: `busy_o` equals `busy_i` from one cycle earlier.
- R9: While `rst` is high at a rising clock edge, every output is 0 after that edge.
- R10: On each of the W and R channels, the stall, buffer-stall and handshake flags are never high together. At most one of them is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_len | input | LEN_W | Write burst length minus one |
| aw_size | input | SIZE_W | Write beat size exponent |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_len | input | LEN_W | Read burst length minus one |
| ar_size | input | SIZE_W | Read beat size exponent |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_strb | input | DATA_W/8 | Write byte strobes |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| busy_i | input | 1 | Engine busy indication |
| aw_stall_o | output | 1 | AW held by subordinate |
| ar_stall_o | output | 1 | AR held by subordinate |
| w_stall_o | output | 1 | W held by subordinate |
| w_idle_o | output | 1 | W ready with no data offered |
| r_stall_o | output | 1 | R ready but no data returned |
| r_idle_o | output | 1 | R data offered but not accepted |
| aw_done_o | output | 1 | AW handshake |
| ar_done_o | output | 1 | AR handshake |
| w_done_o | output | 1 | W handshake |
| r_done_o | output | 1 | R handshake |
| b_done_o | output | 1 | B handshake |
| busy_o | output | 1 | Registered busy |
| aw_bytes_o | output | LEN_W+2^SIZE_W | Bytes of the accepted write burst |
| ar_bytes_o | output | LEN_W+2^SIZE_W | Bytes of the accepted read burst |
| w_bytes_o | output | clog2(DATA_W/8)+1 | Bytes in the accepted write beat |
| r_bytes_o | output | clog2(DATA_W/8)+1 | Bytes in the accepted read beat |

## Verification
The bench builds the monitor with a 32-bit data bus, an 8-bit length field and a 3-bit size field. With the narrow bus, all sixteen strobe patterns appear often under random stimulus, so the full range of W beat byte counts is covered. The full size field allows bursts of up to 256 beats of 128 bytes each, which exercises the widest address byte count of 32768 at the top of the output width. Directed cycles add the extreme lengths and sizes, full and empty strobes, and reset with the channels active.

// File: rtl/axi_evt_pkg.sv
package axi_evt_pkg;

    // Classified state of one valid/ready pair in a single cycle
    typedef struct packed {
        logic stall;   // manager held up by subordinate
        logic idle;    // subordinate ready, manager not
        logic done;    // transfer happened
    } chan_evt_t;

    localparam chan_evt_t CHAN_EVT_NONE = '{stall: 1'b0, idle: 1'b0, done: 1'b0};

    function automatic int unsigned beat_width(input int unsigned strb_w);
        return $clog2(strb_w) + 1;
    endfunction

endpackage

// File: rtl/axi_chan_classify.sv
module axi_chan_classify
    import axi_evt_pkg::*;
#(
    parameter bit MGR_DRIVES_VALID = 1'b1
) (
    input  logic      valid,
    input  logic      ready,
    output chan_evt_t evt
);
    generate
        if (MGR_DRIVES_VALID) begin : g_mgr_valid
            // Manager sources the payload: waiting on ready is a stall
            always_comb begin
                evt.stall = valid & ~ready;
                evt.idle  = ready & ~valid;
                evt.done  = valid &  ready;
            end
        end else begin : g_mgr_ready
            // Manager sinks the payload: waiting on valid is a stall
            always_comb begin
                evt.stall = ready & ~valid;
                evt.idle  = valid & ~ready;
                evt.done  = valid &  ready;
            end
        end
    endgenerate
endmodule

// File: rtl/axi_burst_bytes.sv
module axi_burst_bytes #(
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned SIZE_W = 3,
    localparam int unsigned OUT_W = LEN_W + (1 << SIZE_W)
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    output logic [OUT_W-1:0]  bytes
);
    logic [OUT_W-1:0] beats;

    always_comb begin
        beats = OUT_W'(len) + OUT_W'(1);
        bytes = beats << size;
    end
endmodule

// File: rtl/axi_strb_count.sv
module axi_strb_count #(
    parameter int unsigned STRB_W = 8,
    localparam int unsigned OUT_W = $clog2(STRB_W) + 1
) (
    input  logic [STRB_W-1:0] strb,
    output logic [OUT_W-1:0]  count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < STRB_W; i++) begin
            count = count + OUT_W'(strb[i]);
        end
    end
endmodule

// File: rtl/axi_activity_monitor.sv
module axi_activity_monitor
    import axi_evt_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned SIZE_W  = 3,
    localparam int unsigned STRB_W  = DATA_W / 8,
    localparam int unsigned BEAT_W  = $clog2(STRB_W) + 1,
    localparam int unsigned BURST_W = LEN_W + (1 << SIZE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               aw_valid,
    input  logic               aw_ready,
    input  logic [LEN_W-1:0]   aw_len,
    input  logic [SIZE_W-1:0]  aw_size,
    input  logic               ar_valid,
    input  logic               ar_ready,
    input  logic [LEN_W-1:0]   ar_len,
    input  logic [SIZE_W-1:0]  ar_size,
    input  logic               w_valid,
    input  logic               w_ready,
    input  logic [STRB_W-1:0]  w_strb,
    input  logic               r_valid,
    input  logic               r_ready,
    input  logic               b_valid,
    input  logic               b_ready,
    input  logic               busy_i,
    output logic               aw_stall_o,
    output logic               ar_stall_o,
    output logic               w_stall_o,
    output logic               w_idle_o,
    output logic               r_stall_o,
    output logic               r_idle_o,
    output logic               aw_done_o,
    output logic               ar_done_o,
    output logic               w_done_o,
    output logic               r_done_o,
    output logic               b_done_o,
    output logic               busy_o,
    output logic [BURST_W-1:0] aw_bytes_o,
    output logic [BURST_W-1:0] ar_bytes_o,
    output logic [BEAT_W-1:0]  w_bytes_o,
    output logic [BEAT_W-1:0]  r_bytes_o
);
    localparam logic [BEAT_W-1:0] FULL_BEAT = BEAT_W'(STRB_W);

    chan_evt_t aw_evt, ar_evt, w_evt, r_evt;
    logic [BURST_W-1:0] aw_burst, ar_burst;
    logic [BEAT_W-1:0]  w_cnt;

    axi_chan_classify #(.MGR_DRIVES_VALID(1'b1)) u_cls_aw (
        .valid(aw_valid), .ready(aw_ready), .evt(aw_evt));
    axi_chan_classify #(.MGR_DRIVES_VALID(1'b1)) u_cls_ar (
        .valid(ar_valid), .ready(ar_ready), .evt(ar_evt));
    axi_chan_classify #(.MGR_DRIVES_VALID(1'b1)) u_cls_w (
        .valid(w_valid), .ready(w_ready), .evt(w_evt));
    axi_chan_classify #(.MGR_DRIVES_VALID(1'b0)) u_cls_r (
        .valid(r_valid), .ready(r_ready), .evt(r_evt));

    axi_burst_bytes #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_aw_bytes (
        .len(aw_len), .size(aw_size), .bytes(aw_burst));
    axi_burst_bytes #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_ar_bytes (
        .len(ar_len), .size(ar_size), .bytes(ar_burst));

    axi_strb_count #(.STRB_W(STRB_W)) u_w_cnt (
        .strb(w_strb), .count(w_cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_stall_o <= 1'b0;
            ar_stall_o <= 1'b0;
            w_stall_o  <= 1'b0;
            w_idle_o   <= 1'b0;
            r_stall_o  <= 1'b0;
            r_idle_o   <= 1'b0;
            aw_done_o  <= 1'b0;
            ar_done_o  <= 1'b0;
            w_done_o   <= 1'b0;
            r_done_o   <= 1'b0;
            b_done_o   <= 1'b0;
            busy_o     <= 1'b0;
            aw_bytes_o <= '0;
            ar_bytes_o <= '0;
            w_bytes_o  <= '0;
            r_bytes_o  <= '0;
        end else begin
            aw_stall_o <= aw_evt.stall;
            ar_stall_o <= ar_evt.stall;
            w_stall_o  <= w_evt.stall;
            w_idle_o   <= w_evt.idle;
            r_stall_o  <= r_evt.stall;
            r_idle_o   <= r_evt.idle;
            aw_done_o  <= aw_evt.done;
            ar_done_o  <= ar_evt.done;
            w_done_o   <= w_evt.done;
            r_done_o   <= r_evt.done;
            b_done_o   <= b_valid & b_ready;
            busy_o     <= busy_i;
            aw_bytes_o <= aw_evt.done ? aw_burst  : '0;
            ar_bytes_o <= ar_evt.done ? ar_burst  : '0;
            w_bytes_o  <= w_evt.done  ? w_cnt     : '0;
            r_bytes_o  <= r_evt.done  ? FULL_BEAT : '0;
        end
    end

    // R1
    aw_stall_chk: assert property (@(posedge clk) disable iff (rst)
        aw_stall_o |-> $past(aw_valid && !aw_ready));

    // R3
    r_stall_chk: assert property (@(posedge clk) disable iff (rst)
        r_stall_o |-> $past(r_ready && !r_valid));

    // R10
    w_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({w_stall_o, w_idle_o, w_done_o}) <= 1);

    // R10
    r_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({r_stall_o, r_idle_o, r_done_o}) <= 1);

    // R5
    aw_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        (aw_done_o |-> aw_bytes_o != '0) and (!aw_done_o |-> aw_bytes_o == '0));

    // R6
    w_bytes_range_chk: assert property (@(posedge clk) disable iff (rst)
        w_bytes_o <= FULL_BEAT);

    // R8
    busy_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> busy_o == $past(busy_i));

endmodule

// File: tb/test_axi_activity_monitor.sv
module test_axi_activity_monitor;
    localparam int DATA_W  = 32;
    localparam int LEN_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int STRB_W  = DATA_W / 8;
    localparam int BEAT_W  = $clog2(STRB_W) + 1;
    localparam int BURST_W = LEN_W + (1 << SIZE_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic aw_valid = 0, aw_ready = 0, ar_valid = 0, ar_ready = 0;
    logic w_valid = 0, w_ready = 0, r_valid = 0, r_ready = 0;
    logic b_valid = 0, b_ready = 0, busy_i = 0;
    logic [LEN_W-1:0]  aw_len = '0, ar_len = '0;
    logic [SIZE_W-1:0] aw_size = '0, ar_size = '0;
    logic [STRB_W-1:0] w_strb = '0;
    logic aw_stall_o, ar_stall_o, w_stall_o, w_idle_o, r_stall_o, r_idle_o;
    logic aw_done_o, ar_done_o, w_done_o, r_done_o, b_done_o, busy_o;
    logic [BURST_W-1:0] aw_bytes_o, ar_bytes_o;
    logic [BEAT_W-1:0]  w_bytes_o, r_bytes_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit have_exp = 0;
    int e[16];   // expected value of each output, in port order

    always #5 clk = ~clk;

    axi_activity_monitor #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) i_axi_activity_monitor (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len), .aw_size(aw_size),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len), .ar_size(ar_size),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(w_strb),
        .r_valid(r_valid), .r_ready(r_ready), .b_valid(b_valid), .b_ready(b_ready),
        .busy_i(busy_i),
        .aw_stall_o(aw_stall_o), .ar_stall_o(ar_stall_o), .w_stall_o(w_stall_o),
        .w_idle_o(w_idle_o), .r_stall_o(r_stall_o), .r_idle_o(r_idle_o),
        .aw_done_o(aw_done_o), .ar_done_o(ar_done_o), .w_done_o(w_done_o),
        .r_done_o(r_done_o), .b_done_o(b_done_o), .busy_o(busy_o),
        .aw_bytes_o(aw_bytes_o), .ar_bytes_o(ar_bytes_o),
        .w_bytes_o(w_bytes_o), .r_bytes_o(r_bytes_o));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model: what the outputs must show after the next edge
    task automatic model();
        int ones;
        ones = 0;
        for (int i = 0; i < STRB_W; i++) ones += int'(w_strb[i]);
        foreach (e[k]) e[k] = 0;
        if (!rst) begin
            e[0]  = int'(aw_valid && !aw_ready);
            e[1]  = int'(ar_valid && !ar_ready);
            e[2]  = int'(w_valid && !w_ready);
            e[3]  = int'(w_ready && !w_valid);
            e[4]  = int'(r_ready && !r_valid);
            e[5]  = int'(r_valid && !r_ready);
            e[6]  = int'(aw_valid && aw_ready);
            e[7]  = int'(ar_valid && ar_ready);
            e[8]  = int'(w_valid && w_ready);
            e[9]  = int'(r_valid && r_ready);
            e[10] = int'(b_valid && b_ready);
            e[11] = int'(busy_i);
            e[12] = e[6] ? (int'(aw_len) + 1) * (1 << int'(aw_size)) : 0;
            e[13] = e[7] ? (int'(ar_len) + 1) * (1 << int'(ar_size)) : 0;
            e[14] = e[8] ? ones : 0;
            e[15] = e[9] ? STRB_W : 0;
        end
    endtask

    task automatic compare(input bit in_reset);
        if (in_reset) begin
            // R9: all outputs cleared by reset
            chk("R9", "any event", int'(|{aw_stall_o, ar_stall_o, w_stall_o, w_idle_o,
                r_stall_o, r_idle_o, aw_done_o, ar_done_o, w_done_o, r_done_o,
                b_done_o, busy_o}), 0);
            chk("R9", "bytes", int'(|{aw_bytes_o, ar_bytes_o, w_bytes_o, r_bytes_o}), 0);
            return;
        end
        chk("R1", "aw_stall", int'(aw_stall_o), e[0]);
        chk("R1", "ar_stall", int'(ar_stall_o), e[1]);
        chk("R2", "w_stall",  int'(w_stall_o),  e[2]);
        chk("R2", "w_idle",   int'(w_idle_o),   e[3]);
        chk("R3", "r_stall",  int'(r_stall_o),  e[4]);
        chk("R3", "r_idle",   int'(r_idle_o),   e[5]);
        chk("R4", "aw_done",  int'(aw_done_o),  e[6]);
        chk("R4", "ar_done",  int'(ar_done_o),  e[7]);
        chk("R4", "w_done",   int'(w_done_o),   e[8]);
        chk("R4", "r_done",   int'(r_done_o),   e[9]);
        chk("R4", "b_done",   int'(b_done_o),   e[10]);
        chk("R8", "busy",     int'(busy_o),     e[11]);
        chk("R5", "aw_bytes", int'(aw_bytes_o), e[12]);
        chk("R5", "ar_bytes", int'(ar_bytes_o), e[13]);
        chk("R6", "w_bytes",  int'(w_bytes_o),  e[14]);
        chk("R7", "r_bytes",  int'(r_bytes_o),  e[15]);
        // R10: channel classes exclusive
        chk("R10", "w exclusive", int'($countones({w_stall_o, w_idle_o, w_done_o}) <= 1), 1);
        chk("R10", "r exclusive", int'($countones({r_stall_o, r_idle_o, r_done_o}) <= 1), 1);
    endtask

    // One cycle: check the previous cycle's result, then apply new stimulus
    task automatic step(input logic [31:0] ctl, input logic [LEN_W-1:0] al, input logic [SIZE_W-1:0] asz,
                        input logic [LEN_W-1:0] rl, input logic [SIZE_W-1:0] rsz,
                        input logic [STRB_W-1:0] st, input bit r);
        bit was_reset;
        @(negedge clk);
        was_reset = rst;
        if (have_exp) compare(was_reset);
        rst = r;
        {busy_i, b_ready, b_valid, r_ready, r_valid, w_ready, w_valid,
         ar_ready, ar_valid, aw_ready, aw_valid} = ctl[10:0];
        aw_len = al; aw_size = asz; ar_len = rl; ar_size = rsz; w_strb = st;
        model();
        have_exp = 1;
    endtask

    task automatic rnd_step(input bit r);
        step($urandom, LEN_W'($urandom), SIZE_W'($urandom), LEN_W'($urandom),
             SIZE_W'($urandom), STRB_W'($urandom), r);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // Reset held with busy channels (R9)
        for (int i = 0; i < 4; i++) rnd_step(1'b1);
        step(32'h7FF, '0, '0, '0, '0, '1, 1'b1);
        // Directed corners: largest and smallest bursts, full strobes (R5, R6, R7)
        step(32'h7FF, 8'hFF, 3'd7, 8'h00, 3'd0, 4'hF, 1'b0);
        step(32'h7FF, 8'h00, 3'd0, 8'hFF, 3'd7, 4'h0, 1'b0);
        step(32'h7FF, 8'h0F, 3'd2, 8'h03, 3'd3, 4'b0101, 1'b0);
        // Every stall-type pattern per channel (R1, R2, R3)
        step(32'b000_0101_0101, '0, '0, '0, '0, '0, 1'b0);
        step(32'b000_1010_1010, '0, '0, '0, '0, '0, 1'b0);
        step(32'h000, '0, '0, '0, '0, '0, 1'b0);
        // Random traffic (all requirements)
        for (int i = 0; i < 3000; i++) rnd_step(1'b0);
        // Reset in mid traffic, then recovery
        rnd_step(1'b1);
        rnd_step(1'b1);
        for (int i = 0; i < 200; i++) rnd_step(1'b0);
        step(32'h0, '0, '0, '0, '0, '0, 1'b0);
        step(32'h0, '0, '0, '0, '0, '0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule